// File: doc/BRIEF.md
# Interrupt Acceptance and Sequencing Unit

This unit sits beside a processor core and decides, cycle by cycle, whether a pending interrupt is taken, and which vector goes with it. Two sources feed it. The first is a level-sensitive maskable request from an external interrupt controller. The second is a one-cycle pulse that an upstream input qualifier produces for each non-maskable event. The unit also keeps the interrupt-enable flag. Software sets or clears this flag through strobes, and the unit clears it on its own whenever it takes an interrupt.

A non-maskable event gets the fixed vector 2 and runs no bus traffic. A maskable request starts two back-to-back acknowledge bus cycles, with the bus held locked for both. The vector is captured from the data bus when the second cycle completes. A handler nesting counter tracks the active handlers and the level at which a non-maskable handler runs. A return strobe at that level ends the non-maskable handler. Until it ends, one further non-maskable event is held pending and later ones are dropped. The pending event is issued as soon as the handler ends.

Top module: `irq_sequencer`

## Requirements
- R1: A maskable request is accepted only while `ie_o` is 1 and `mreq_i` is 1. On acceptance, `lock_o` goes high in the next cycle with `ack_phase_o` = 0.
- R2: Every accepted interrupt clears `ie_o` at the acceptance edge. Otherwise `ie_set_i` sets the flag and `ie_clr_i` clears it. Acceptance overrides `ie_set_i`.
- R3: A maskable request seen while `ie_o` is 0 is not remembered. Once it has dropped, setting `ie_o` starts no acknowledge sequence.
- R4: A pulse on `nmi_i` while no non-maskable handler is active gives `take_o` = 1 in the next cycle, with `take_nmi_o` = 1, `take_vec_o` = 8'h02 and `nmi_act_o` = 1.
- R5: A non-maskable pulse while `nmi_act_o` is 1 is stored in a single pending slot. It is taken one cycle after the return that ends that handler. Further pulses while the slot is full are lost.
- R6: The acknowledge sequence holds `lock_o` = 1 through two phases. `ack_phase_o` is 0 in the first phase and 1 in the second. Each phase ends on a cycle with `ack_rdy_i` = 1. `data_i` is sampled at the end of the second phase, and `take_o` = 1 follows in the next cycle with `take_nmi_o` = 0. A non-maskable take never follows a locked cycle.
- R7: When a maskable and a non-maskable request can both be accepted in the same cycle, the non-maskable one is taken and no acknowledge sequence starts.
- R8: Each take increments `depth_o` and each `iret_i` decrements it (a return at depth 0 is ignored). An interrupt taken inside another handler is serviced at once. `nmi_act_o` clears only on the return that brings `depth_o` below the level the non-maskable handler was taken at.
- R9: No interrupt is accepted while `lock_o` is 1, while `depth_o` equals MAX_DEPTH, or in a cycle with `iret_i` = 1. A non-maskable pulse in such a cycle is held pending. `depth_o` never exceeds MAX_DEPTH.
- R10: After reset, `take_o`, `lock_o`, `ie_o`, `nmi_act_o` and `depth_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_i | input | 1 | Maskable request level |
| nmi_i | input | 1 | Qualified non-maskable pulse, one cycle per event |
| ie_set_i | input | 1 | Set the interrupt-enable flag |
| ie_clr_i | input | 1 | Clear the interrupt-enable flag |
| iret_i | input | 1 | Return-from-interrupt strobe |
| ack_rdy_i | input | 1 | Ends the current acknowledge phase |
| data_i | input | 8 | Data bus; the vector is read here in the second phase |
| lock_o | output | 1 | Bus locked; an acknowledge sequence is running |
| ack_phase_o | output | 1 | 0 in the first acknowledge phase, 1 in the second |
| take_o | output | 1 | One-cycle strobe: interrupt taken |
| take_nmi_o | output | 1 | Interrupt type with take_o (1 = non-maskable) |
| take_vec_o | output | 8 | Vector with take_o |
| ie_o | output | 1 | Interrupt-enable flag |
| nmi_act_o | output | 1 | A non-maskable handler is active |
| depth_o | output | $clog2(MAX_DEPTH+1) | Handler nesting depth |

## Verification
Every result is one register stage away from the edge that decides it. A non-maskable take, and `lock_o` after a maskable acceptance, appear in the cycle right after the sampled request. The maskable take appears one cycle after the `ack_rdy_i` of the second phase. A pending non-maskable event is taken two cycles after the `iret_i` that ends its handler: one edge clears the active flag and the next accepts the event. Inputs change at the falling edge, and every check is made at the next falling edge, after exactly one rising edge. Each expected value therefore refers to a known edge count, and the bench steps through multi-cycle sequences one edge at a time.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_SECOND = 2'd2
  } ack_state_e;

  localparam logic [7:0] NMI_VEC = 8'h02;
endpackage

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rdy_i,
  output logic busy_o,
  output logic phase_o,
  output logic done_o
);
  ack_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ACK_IDLE:   if (start_i) st_d = ACK_FIRST;
      ACK_FIRST:  if (rdy_i)   st_d = ACK_SECOND;
      ACK_SECOND: if (rdy_i)   st_d = ACK_IDLE;
      default:                 st_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ACK_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o  = (st_q != ACK_IDLE);
  assign phase_o = (st_q == ACK_SECOND);
  assign done_o  = (st_q == ACK_SECOND) && rdy_i;

  AST_PHASE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ACK_FIRST && rdy_i) |=> (st_q == ACK_SECOND)); // R6
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ACK_SECOND && !rdy_i) |=> (st_q == ACK_SECOND)); // R6
endmodule

// File: rtl/irq_nest.sv
module irq_nest #(
  parameter int MAX_DEPTH = 4,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          push_nmi_i,
  input  logic          pop_i,
  output logic [DW-1:0] depth_o,
  output logic          full_o,
  output logic          nmi_act_o
);
  logic [DW-1:0] depth_q, lvl_q;
  logic          nmi_q;
  logic          pop_ok;

  assign pop_ok = pop_i && (depth_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      lvl_q   <= '0;
      nmi_q   <= 1'b0;
    end else begin
      if (push_i && !pop_ok)      depth_q <= depth_q + 1'b1;
      else if (pop_ok && !push_i) depth_q <= depth_q - 1'b1;
      if (push_nmi_i) begin
        nmi_q <= 1'b1;
        lvl_q <= depth_q + 1'b1;
      end else if (pop_ok && nmi_q && depth_q == lvl_q) begin
        nmi_q <= 1'b0;
      end
    end
  end

  assign depth_o   = depth_q;
  assign full_o    = (depth_q == DW'(MAX_DEPTH));
  assign nmi_act_o = nmi_q;

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= DW'(MAX_DEPTH)); // R9
  AST_NMI_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_nmi_i |-> !nmi_q); // R4
endmodule

// File: rtl/irq_arb.sv
module irq_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mreq_i,
  input  logic nmi_i,
  input  logic ie_set_i,
  input  logic ie_clr_i,
  input  logic iret_i,
  input  logic busy_i,
  input  logic full_i,
  input  logic nmi_act_i,
  output logic acc_nmi_o,
  output logic acc_mask_o,
  output logic ie_o
);
  logic ie_q, pend_q;
  logic can_acc, nmi_req;

  // returns and running acknowledge sequences block new acceptance
  assign can_acc    = !busy_i && !full_i && !iret_i;
  assign nmi_req    = nmi_i || pend_q;
  assign acc_nmi_o  = nmi_req && !nmi_act_i && can_acc;
  assign acc_mask_o = mreq_i && ie_q && can_acc && !acc_nmi_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= acc_nmi_o ? 1'b0 : nmi_req;
      if (acc_nmi_o || acc_mask_o) ie_q <= 1'b0;
      else if (ie_set_i)           ie_q <= 1'b1;
      else if (ie_clr_i)           ie_q <= 1'b0;
    end
  end

  assign ie_o = ie_q;

  AST_NMI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && mreq_i && ie_q && can_acc && !nmi_act_i) |=> !busy_i); // R7
  AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && nmi_act_i) |=> pend_q); // R5
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_pkg::*;
#(
  parameter int MAX_DEPTH = 4,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mreq_i,
  input  logic          nmi_i,
  input  logic          ie_set_i,
  input  logic          ie_clr_i,
  input  logic          iret_i,
  input  logic          ack_rdy_i,
  input  logic [7:0]    data_i,
  output logic          lock_o,
  output logic          ack_phase_o,
  output logic          take_o,
  output logic          take_nmi_o,
  output logic [7:0]    take_vec_o,
  output logic          ie_o,
  output logic          nmi_act_o,
  output logic [DW-1:0] depth_o
);
  logic busy, done, full, nmi_act;
  logic acc_nmi, acc_mask;
  logic take_q, take_nmi_q;
  logic [7:0] vec_q;

  irq_arb u_arb (
    .clk_i, .rst_ni, .mreq_i, .nmi_i, .ie_set_i, .ie_clr_i, .iret_i,
    .busy_i(busy), .full_i(full), .nmi_act_i(nmi_act),
    .acc_nmi_o(acc_nmi), .acc_mask_o(acc_mask), .ie_o(ie_o)
  );

  irq_ack_fsm u_ack (
    .clk_i, .rst_ni, .start_i(acc_mask), .rdy_i(ack_rdy_i),
    .busy_o(busy), .phase_o(ack_phase_o), .done_o(done)
  );

  irq_nest #(.MAX_DEPTH(MAX_DEPTH)) u_nest (
    .clk_i, .rst_ni, .push_i(acc_nmi || done), .push_nmi_i(acc_nmi),
    .pop_i(iret_i), .depth_o(depth_o), .full_o(full), .nmi_act_o(nmi_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q     <= 1'b0;
      take_nmi_q <= 1'b0;
      vec_q      <= '0;
    end else begin
      take_q     <= acc_nmi || done;
      take_nmi_q <= acc_nmi;
      if (acc_nmi)   vec_q <= NMI_VEC;
      else if (done) vec_q <= data_i;
    end
  end

  assign lock_o     = busy;
  assign take_o     = take_q;
  assign take_nmi_o = take_nmi_q;
  assign take_vec_o = vec_q;
  assign nmi_act_o  = nmi_act;

  AST_MASK_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(ie_o)); // R1
  AST_IE_CLR_ON_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_nmi_o) |-> !ie_o); // R2
  AST_NMI_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_nmi_o) |-> !$past(lock_o)); // R6
  AST_NMI_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_nmi_o) |-> nmi_act_o); // R4
endmodule

// File: tb/irq_sequencer_tb.sv
module irq_sequencer_tb;
  localparam int MAXD = 4;
  localparam int DW = $clog2(MAXD + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mreq = 0, nmi = 0, ie_set = 0, ie_clr = 0, iret = 0, rdy = 0;
  logic [7:0] data = '0;
  logic lock, phase, take, take_nmi, ie, nmi_act;
  logic [7:0] vec;
  logic [DW-1:0] depth;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_sequencer #(.MAX_DEPTH(MAXD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mreq_i(mreq), .nmi_i(nmi),
    .ie_set_i(ie_set), .ie_clr_i(ie_clr), .iret_i(iret), .ack_rdy_i(rdy),
    .data_i(data), .lock_o(lock), .ack_phase_o(phase), .take_o(take),
    .take_nmi_o(take_nmi), .take_vec_o(vec), .ie_o(ie), .nmi_act_o(nmi_act),
    .depth_o(depth)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic enable();
    ie_set = 1; tick(); ie_set = 0;
  endtask

  task automatic ret(input int exp_depth);
    iret = 1; tick(); iret = 0;
    chk("R8 depth after return", int'(depth), exp_depth);
  endtask

  // maskable sequence; ie_o must already be set
  task automatic mask_seq(input logic [7:0] v, input int w1, input int w2, input int exp_depth);
    mreq = 1; tick(); mreq = 0;
    chk("R1 lock after accept", int'(lock), 1);
    chk("R6 first phase", int'(phase), 0);
    chk("R2 ie cleared on accept", int'(ie), 0);
    for (int i = 0; i < w1; i++) begin
      tick(); chk("R6 first phase holds", int'({lock, phase}), 2);
    end
    rdy = 1; tick(); rdy = 0;
    chk("R6 second phase", int'({lock, phase}), 3);
    for (int i = 0; i < w2; i++) begin
      tick(); chk("R6 second phase holds", int'({lock, phase}), 3);
      chk("R6 no take before ready", int'(take), 0);
    end
    data = v; rdy = 1; tick(); rdy = 0; data = 8'hxx;
    chk("R6 take strobe", int'(take), 1);
    chk("R6 take type", int'(take_nmi), 0);
    chk("R6 vector", int'(vec), int'(v));
    chk("R6 lock released", int'(lock), 0);
    chk("R8 depth", int'(depth), exp_depth);
    tick(); chk("R6 take single cycle", int'(take), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    data = '0;
    repeat (3) @(negedge clk);
    chk("R10 take reset", int'(take), 0);
    chk("R10 lock reset", int'(lock), 0);
    chk("R10 ie reset", int'(ie), 0);
    chk("R10 nmi_act reset", int'(nmi_act), 0);
    chk("R10 depth reset", int'(depth), 0);
    rst_ni = 1; tick();

    // R3: request while disabled is not remembered
    mreq = 1; repeat (3) tick();
    chk("R3 no accept while disabled", int'(lock), 0);
    mreq = 0; enable();
    chk("R2 ie set", int'(ie), 1);
    repeat (2) tick();
    chk("R3 dropped request not latched", int'(lock | take), 0);
    ie_clr = 1; tick(); ie_clr = 0;
    chk("R2 ie clear strobe", int'(ie), 0);

    // R1/R6 sweep over vectors and wait states
    for (int k = 0; k < 9; k++) begin
      enable();
      mask_seq(8'((k * 53 + 9) & 255), k % 3, (k / 3) % 3, 1);
      ret(0);
    end

    // R4: single NMI
    nmi = 1; tick(); nmi = 0;
    chk("R4 take", int'(take), 1);
    chk("R4 type", int'(take_nmi), 1);
    chk("R4 vector 2", int'(vec), 2);
    chk("R4 no lock", int'(lock), 0);
    chk("R4 nmi active", int'(nmi_act), 1);
    chk("R2 ie stays clear", int'(ie), 0);
    // R5: two more pulses, only one kept
    nmi = 1; tick(); nmi = 0;
    chk("R5 no take while active", int'(take), 0);
    tick();
    nmi = 1; tick(); nmi = 0;
    chk("R5 no take second pulse", int'(take), 0);
    ret(0);
    chk("R5 nmi ended", int'(nmi_act), 0);
    chk("R5 no take on return edge", int'(take), 0);
    tick();
    chk("R5 pending taken", int'(take & take_nmi), 1);
    chk("R5 depth", int'(depth), 1);
    ret(0);
    tick();
    chk("R5 extra pulse dropped", int'(take), 0);

    // R8: maskable nested inside NMI
    nmi = 1; tick(); nmi = 0;
    enable();
    mask_seq(8'h5c, 1, 0, 2);
    chk("R8 nmi still active", int'(nmi_act), 1);
    ret(1);
    chk("R8 inner return keeps nmi", int'(nmi_act), 1);
    ret(0);
    chk("R8 outer return ends nmi", int'(nmi_act), 0);

    // R7: simultaneous requests
    enable();
    mreq = 1; nmi = 1; tick(); nmi = 0;
    chk("R7 nmi wins", int'(take & take_nmi), 1);
    chk("R7 no acknowledge", int'(lock), 0);
    tick();
    chk("R7 no later acknowledge", int'(lock), 0);
    mreq = 0;
    ret(0);

    // R9: NMI during acknowledge is held
    enable();
    mreq = 1; tick(); mreq = 0;
    nmi = 1; tick(); nmi = 0;
    chk("R9 no take while locked", int'(take), 0);
    rdy = 1; tick();
    data = 8'ha7; tick(); rdy = 0;
    chk("R9 maskable take first", int'(take & ~take_nmi), 1);
    chk("R9 maskable vector", int'(vec), 8'ha7);
    tick();
    chk("R9 held nmi taken", int'(take & take_nmi), 1);
    chk("R9 depth two", int'(depth), 2);
    ret(1);
    ret(0);

    // R9: NMI in a return cycle is held
    nmi = 1; iret = 1; tick(); nmi = 0; iret = 0;
    chk("R8 return at zero ignored", int'(depth), 0);
    chk("R9 no take in return cycle", int'(take), 0);
    tick();
    chk("R9 pulse from return cycle taken", int'(take & take_nmi), 1);
    ret(0);

    // R9: full depth
    for (int d = 1; d <= MAXD; d++) begin
      enable();
      mask_seq(8'(d + 16), 0, 1, d);
    end
    enable();
    mreq = 1; repeat (2) tick();
    chk("R9 no accept when full", int'(lock), 0);
    mreq = 0;
    nmi = 1; tick(); nmi = 0;
    chk("R9 nmi held when full", int'(take), 0);
    chk("R9 depth capped", int'(depth), MAXD);
    ret(MAXD - 1);
    tick();
    chk("R9 held nmi after room", int'(take & take_nmi), 1);
    chk("R9 depth back at max", int'(depth), MAXD);
    for (int d = MAXD - 1; d >= 0; d--) ret(d);
    chk("R8 nmi ended at its level", int'(nmi_act), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule